// File: doc/BRIEF.md
# Superframe Overhead Bit Transmitter

This block keeps the transmit-side overhead registers of a 2B1Q line framer and hands the framer one complete set of M4, M5 and M6 overhead bits for each outgoing superframe. A host programs three byte-wide registers through a plain write/read register port. The framer pulses a superframe strobe once per superframe. On that strobe, while the link sits in its fully active signalling states, the block loads a frame register from a shadow of the host values. Three activation positions of the M4 word are taken from an external activation sequencer at that moment.

The far-end block error bit (febe) is normally 1. It is driven to 0 by any of three sources:
- a one-shot host request, which clears itself once it has been sent;
- a failed local CRC result, when that source is enabled;
- a permanent force.

When more than one source is active in the same superframe, a single febe of 0 goes out. The framer serialises the frame register outputs; scrambling, CRC computation and line coding live elsewhere.

Register map (address: contents):
- 0, M4 word: bit7 = act, bit6 = dea, bit1 = uoa/sai (these three come from the sequencer), and bits 5..2 and 0 are host spares.
- 1, M5/M6 word: bit0 = M51, bit1 = M52, bit2 = M61, bits 4 and 3 = febe request bits, bits 7..5 read as 0.
- 2, control: bit0 = host-request enable (RQE), bit1 = CRC-source enable (CSE), bit2 = febe-allow (FAL; 0 forces febe to 0), bits 7..3 read as 0.

Top module: `sfov_tx`

## Requirements
- R1: After reset, address 0 reads 0x7D, address 1 reads 0x1F and address 2 reads 0x04. The frame outputs are tx_m4 = 0x7D and tx_m51 = tx_m52 = tx_m61 = tx_febe = 1.
- R2: A strobe with link_active = 1 loads tx_m4 with {act_in, dea_in, host bits 5..2, uoa_in, host bit 0}, and loads tx_m51/tx_m52/tx_m61 from address 1 bits 0/1/2. The outputs take these values on the clock edge that samples the strobe.
- R3: A strobe with link_active = 0 changes no frame output and leaves a pending febe request pending.
- R4: Host writes to address 0 bits 7, 6 and 1 are ignored. Reading those bits returns the values in tx_m4 at that moment.
- R5: A register write reaches the frame outputs only at the next strobe edge. A write sampled on the same edge as a strobe appears in the frame loaded by the following strobe.
- R6: With RQE = 1, writing 0 to bit 4 or bit 3 of address 1 makes the next loaded frame carry febe = 0. Those bits read 0 while the request is pending and read 1 once it has been sent. The frame after that carries febe = 1.
- R7: With RQE = 0, writing 0 to address 1 bits 4/3 has no effect: febe stays 1 and the bits read 1.
- R8: With CSE = 1, a strobe that samples crc_ok = 0 loads febe = 0. With CSE = 0, crc_ok has no effect on febe.
- R9: While FAL = 0, every loaded frame carries febe = 0.
- R10: When several febe sources are active at one strobe, that frame carries febe = 0 once, the host request is cleared, and the next frame carries febe = 1 if no other source remains.
- R11: A host febe request written in the same cycle as a strobe does not affect the frame loaded by that strobe. It is carried by the next loaded frame.
- R12: Reads of address 3 return 0, and writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 8 | Combinational read data |
| sf_strobe | input | 1 | One-cycle pulse per superframe boundary |
| link_active | input | 1 | Transmitter is in a fully active signalling state |
| act_in | input | 1 | Activation bit act from the sequencer |
| dea_in | input | 1 | Activation bit dea from the sequencer |
| uoa_in | input | 1 | Activation bit uoa/sai from the sequencer |
| crc_ok | input | 1 | Local CRC result for the frame, 1 = good |
| tx_m4 | output | 8 | M4 overhead word of the current frame |
| tx_m51 | output | 1 | M51 spare bit of the current frame |
| tx_m52 | output | 1 | M52 spare bit of the current frame |
| tx_m61 | output | 1 | M61 spare bit of the current frame |
| tx_febe | output | 1 | febe bit of the current frame |

## Verification
The properties assume that sf_strobe is a single-cycle pulse. They also assume that act_in, dea_in, uoa_in and crc_ok are steady in the cycle the strobe is sampled, since only that cycle's values are meant to be latched. The bench changes every input right after a falling edge and keeps each strobe to one cycle. The bench also assumes the host never issues a febe request and a control change in the same cycle. The stimulus writes the control register in its own cycle before any febx write, so the enable seen by the request is never ambiguous.

// File: rtl/sfov_pkg.sv
package sfov_pkg;
  localparam int DW = 8;

  localparam int A_M4  = 0;
  localparam int A_M56 = 1;
  localparam int A_CTL = 2;

  localparam logic [DW-1:0] M4_RST  = 8'h7D;
  localparam logic [DW-1:0] M56_RST = 8'h1F;
  localparam logic [DW-1:0] CTL_RST = 8'h04;

  localparam int B_ACT = 7;
  localparam int B_DEA = 6;
  localparam int B_UOA = 1;
  localparam logic [DW-1:0] ACT_MASK = (DW'(1) << B_ACT) | (DW'(1) << B_DEA) | (DW'(1) << B_UOA);

  localparam int B_FBA = 4;
  localparam int B_FBB = 3;
  localparam int SPARE56_W = 3;

  localparam int B_RQE = 0;
  localparam int B_CSE = 1;
  localparam int B_FAL = 2;

  typedef struct packed {
    logic [DW-1:0] m4;
    logic          m51;
    logic          m52;
    logic          m61;
    logic          febe;
  } frame_t;
endpackage

// File: rtl/sfov_rst_sync.sv
module sfov_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sfov_regs.sv
module sfov_regs
  import sfov_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        host_m4,
  output logic [SPARE56_W-1:0] host_m56,
  output logic                 ctl_rqe,
  output logic                 ctl_cse,
  output logic                 ctl_fal,
  output logic                 febx_req
);
  logic [DW-1:0]        m4_q, m4_d;
  logic [SPARE56_W-1:0] m56_q, m56_d;
  logic [2:0]           ctl_q, ctl_d;
  logic                 sel_m4, sel_m56, sel_ctl;

  always_comb begin
    sel_m4  = wr_en && (wr_addr == AW'(A_M4));
    sel_m56 = wr_en && (wr_addr == AW'(A_M56));
    sel_ctl = wr_en && (wr_addr == AW'(A_CTL));

    m4_d  = m4_q;
    m56_d = m56_q;
    ctl_d = ctl_q;
    if (sel_m4)  m4_d  = wr_data & ~ACT_MASK;
    if (sel_m56) m56_d = wr_data[SPARE56_W-1:0];
    if (sel_ctl) ctl_d = wr_data[2:0];

    febx_req = sel_m56 && !(wr_data[B_FBA] && wr_data[B_FBB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m4_q  <= M4_RST & ~ACT_MASK;
      m56_q <= M56_RST[SPARE56_W-1:0];
      ctl_q <= CTL_RST[2:0];
    end else begin
      m4_q  <= m4_d;
      m56_q <= m56_d;
      ctl_q <= ctl_d;
    end
  end

  assign host_m4  = m4_q;
  assign host_m56 = m56_q;
  assign ctl_rqe  = ctl_q[B_RQE];
  assign ctl_cse  = ctl_q[B_CSE];
  assign ctl_fal  = ctl_q[B_FAL];
endmodule

// File: rtl/sfov_febe.sv
module sfov_febe (
  input  logic clk,
  input  logic rst_n,
  input  logic febx_req,
  input  logic ctl_rqe,
  input  logic ctl_cse,
  input  logic ctl_fal,
  input  logic crc_ok,
  input  logic frame_load,
  output logic febx_pend,
  output logic febe_next
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (frame_load)           pend_d = 1'b0;
    if (febx_req && ctl_rqe)  pend_d = 1'b1;
    febe_next = !(pend_q || (ctl_cse && !crc_ok) || !ctl_fal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign febx_pend = pend_q;
endmodule

// File: rtl/sfov_frame.sv
module sfov_frame
  import sfov_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_load,
  input  logic [DW-1:0]        host_m4,
  input  logic [SPARE56_W-1:0] host_m56,
  input  logic                 act_in,
  input  logic                 dea_in,
  input  logic                 uoa_in,
  input  logic                 febe_next,
  output frame_t               frame
);
  frame_t frame_q, frame_d;
  logic [DW-1:0] act_word;

  always_comb begin
    act_word = '0;
    act_word[B_ACT] = act_in;
    act_word[B_DEA] = dea_in;
    act_word[B_UOA] = uoa_in;

    frame_d = frame_q;
    if (frame_load) begin
      frame_d.m4   = (host_m4 & ~ACT_MASK) | act_word;
      frame_d.m51  = host_m56[0];
      frame_d.m52  = host_m56[1];
      frame_d.m61  = host_m56[2];
      frame_d.febe = febe_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q.m4   <= M4_RST;
      frame_q.m51  <= 1'b1;
      frame_q.m52  <= 1'b1;
      frame_q.m61  <= 1'b1;
      frame_q.febe <= 1'b1;
    end else begin
      frame_q <= frame_d;
    end
  end

  assign frame = frame_q;
endmodule

// File: rtl/sfov_tx.sv
module sfov_tx
  import sfov_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          sf_strobe,
  input  logic          link_active,
  input  logic          act_in,
  input  logic          dea_in,
  input  logic          uoa_in,
  input  logic          crc_ok,
  output logic [DW-1:0] tx_m4,
  output logic          tx_m51,
  output logic          tx_m52,
  output logic          tx_m61,
  output logic          tx_febe
);
  logic                 rst_sync_n;
  logic [DW-1:0]        host_m4;
  logic [SPARE56_W-1:0] host_m56;
  logic                 ctl_rqe, ctl_cse, ctl_fal;
  logic                 febx_req, febx_pend, febe_next;
  logic                 frame_load;
  frame_t               frame;

  sfov_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sfov_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .host_m4(host_m4), .host_m56(host_m56),
    .ctl_rqe(ctl_rqe), .ctl_cse(ctl_cse), .ctl_fal(ctl_fal),
    .febx_req(febx_req)
  );

  assign frame_load = sf_strobe && link_active;

  sfov_febe u_febe (
    .clk(clk), .rst_n(rst_sync_n),
    .febx_req(febx_req), .ctl_rqe(ctl_rqe), .ctl_cse(ctl_cse), .ctl_fal(ctl_fal),
    .crc_ok(crc_ok), .frame_load(frame_load),
    .febx_pend(febx_pend), .febe_next(febe_next)
  );

  sfov_frame u_frame (
    .clk(clk), .rst_n(rst_sync_n), .frame_load(frame_load),
    .host_m4(host_m4), .host_m56(host_m56),
    .act_in(act_in), .dea_in(dea_in), .uoa_in(uoa_in),
    .febe_next(febe_next), .frame(frame)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_M4)) begin
      rd_data = (host_m4 & ~ACT_MASK) | (frame.m4 & ACT_MASK);
    end else if (rd_addr == AW'(A_M56)) begin
      rd_data[SPARE56_W-1:0] = host_m56;
      rd_data[B_FBA]         = !febx_pend;
      rd_data[B_FBB]         = !febx_pend;
    end else if (rd_addr == AW'(A_CTL)) begin
      rd_data[B_RQE] = ctl_rqe;
      rd_data[B_CSE] = ctl_cse;
      rd_data[B_FAL] = ctl_fal;
    end
  end

  assign tx_m4   = frame.m4;
  assign tx_m51  = frame.m51;
  assign tx_m52  = frame.m52;
  assign tx_m61  = frame.m61;
  assign tx_febe = frame.febe;
endmodule

// File: rtl/sfov_tx_chk.sv
module sfov_tx_chk
  import sfov_pkg::*;
#(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          act_in,
  input logic          dea_in,
  input logic          uoa_in,
  input logic          crc_ok,
  input logic [DW-1:0] tx_m4,
  input logic          tx_m51,
  input logic          tx_m52,
  input logic          tx_m61,
  input logic          tx_febe,
  input logic          pend,
  input logic          febx_req,
  input logic          rqe,
  input logic          cse,
  input logic          fal,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data
);
  // R2
  act_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tx_m4[B_ACT] == $past(act_in)) && (tx_m4[B_DEA] == $past(dea_in))
             && (tx_m4[B_UOA] == $past(uoa_in)));

  // R3
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(tx_m4) && $stable(tx_m51) && $stable(tx_m52)
              && $stable(tx_m61) && $stable(tx_febe));

  // R4
  act_rdback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(A_M4)) |-> (rd_data[B_ACT] == tx_m4[B_ACT])
      && (rd_data[B_DEA] == tx_m4[B_DEA]) && (rd_data[B_UOA] == tx_m4[B_UOA]));

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && !(febx_req && rqe) |=> !pend);

  // R7
  rqe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rqe && !pend |=> !pend);

  // R8
  crc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && cse && !crc_ok |=> !tx_febe);

  // R9
  fal_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && !fal |=> !tx_febe);

  // R10
  pend_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && pend |=> !tx_febe);
endmodule

bind sfov_tx sfov_tx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .load(frame_load),
  .act_in(act_in), .dea_in(dea_in), .uoa_in(uoa_in), .crc_ok(crc_ok),
  .tx_m4(tx_m4), .tx_m51(tx_m51), .tx_m52(tx_m52), .tx_m61(tx_m61), .tx_febe(tx_febe),
  .pend(febx_pend), .febx_req(febx_req),
  .rqe(ctl_rqe), .cse(ctl_cse), .fal(ctl_fal),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_sfov_tx.sv
`timescale 1ns/1ps
module sim_sfov_tx;
  localparam int AW = 2;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          sf_strobe, link_active, act_in, dea_in, uoa_in, crc_ok;
  logic [7:0]    tx_m4;
  logic          tx_m51, tx_m52, tx_m61, tx_febe;

  int checks;
  int failures;
  bit finished;

  sfov_tx #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sf_strobe(sf_strobe), .link_active(link_active),
    .act_in(act_in), .dea_in(dea_in), .uoa_in(uoa_in), .crc_ok(crc_ok),
    .tx_m4(tx_m4), .tx_m51(tx_m51), .tx_m52(tx_m52), .tx_m61(tx_m61), .tx_febe(tx_febe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
    rd_addr = AW'(a);
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    sf_strobe = 1'b1;
    @(negedge clk);
    sf_strobe = 1'b0;
  endtask

  task automatic wr_strobe(input int a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; sf_strobe = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sf_strobe = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 m4 reg", 0, 8'h7D);
    rd_chk("R1 m56 reg", 1, 8'h1F);
    rd_chk("R1 ctl reg", 2, 8'h04);
    chk("R1 tx_m4", tx_m4, 8'h7D);
    chk("R1 spare/febe", {4'b0, tx_m51, tx_m52, tx_m61, tx_febe}, 8'h0F);
  endtask

  task automatic t_frame();
    link_active = 1'b1; act_in = 1'b1; dea_in = 1'b0; uoa_in = 1'b1;
    wr(0, 8'h00);
    chk("R5 m4 before strobe", tx_m4, 8'h7D);
    strobe();
    chk("R2 m4 load", tx_m4, 8'h82);
    rd_chk("R4 m4 readback", 0, 8'h82);
    act_in = 1'b0; dea_in = 1'b1; uoa_in = 1'b0;
    wr(0, 8'hC2);
    rd_chk("R4 act write ignored", 0, 8'h82);
    strobe();
    chk("R4 m4 act from sequencer", tx_m4, 8'h40);
    wr(1, 8'h1A);
    rd_chk("R2 m56 readback", 1, 8'h1A);
    strobe();
    chk("R2 spare bits", {4'b0, tx_m51, tx_m52, tx_m61, tx_febe}, 8'h05);
  endtask

  task automatic t_inactive();
    link_active = 1'b0; act_in = 1'b1; dea_in = 1'b1; uoa_in = 1'b1;
    wr(0, 8'h3C);
    strobe();
    chk("R3 m4 held when inactive", tx_m4, 8'h40);
    link_active = 1'b1;
    strobe();
    chk("R2 m4 after reactivation", tx_m4, 8'hFE);
  endtask

  task automatic t_strobe_write();
    wr_strobe(0, 8'h01);
    chk("R5 write in strobe cycle", tx_m4, 8'hFE);
    strobe();
    chk("R5 write seen next frame", tx_m4, 8'hC3);
  endtask

  task automatic t_febx_gate_off();
    wr(1, 8'h07);
    rd_chk("R7 febx reads 1", 1, 8'h1F);
    strobe();
    chk("R7 febe stays 1", {7'b0, tx_febe}, 8'h01);
  endtask

  task automatic t_febx_one_shot();
    wr(2, 8'h05);
    wr(1, 8'h07);
    rd_chk("R6 febx pending reads 0", 1, 8'h07);
    link_active = 1'b0;
    strobe();
    chk("R3 febe untouched inactive", {7'b0, tx_febe}, 8'h01);
    rd_chk("R3 request still pending", 1, 8'h07);
    link_active = 1'b1;
    strobe();
    chk("R6 febe sent 0", {7'b0, tx_febe}, 8'h00);
    rd_chk("R6 febx back to 1", 1, 8'h1F);
    strobe();
    chk("R6 febe back to 1", {7'b0, tx_febe}, 8'h01);
  endtask

  task automatic t_febx_in_strobe();
    wr_strobe(1, 8'h07);
    chk("R11 febe not in same frame", {7'b0, tx_febe}, 8'h01);
    rd_chk("R11 request held", 1, 8'h07);
    strobe();
    chk("R11 febe in next frame", {7'b0, tx_febe}, 8'h00);
    strobe();
    chk("R11 febe clears", {7'b0, tx_febe}, 8'h01);
  endtask

  task automatic t_crc();
    wr(2, 8'h06);
    crc_ok = 1'b0;
    strobe();
    chk("R8 crc fail forces 0", {7'b0, tx_febe}, 8'h00);
    crc_ok = 1'b1;
    strobe();
    chk("R8 crc good gives 1", {7'b0, tx_febe}, 8'h01);
    wr(2, 8'h04);
    crc_ok = 1'b0;
    strobe();
    chk("R8 crc source off", {7'b0, tx_febe}, 8'h01);
    crc_ok = 1'b1;
  endtask

  task automatic t_fal();
    wr(2, 8'h00);
    rd_chk("R9 ctl readback", 2, 8'h00);
    strobe();
    chk("R9 febe forced frame 1", {7'b0, tx_febe}, 8'h00);
    strobe();
    chk("R9 febe forced frame 2", {7'b0, tx_febe}, 8'h00);
    wr(2, 8'h04);
    strobe();
    chk("R9 release force", {7'b0, tx_febe}, 8'h01);
  endtask

  task automatic t_combo();
    wr(2, 8'h07);
    crc_ok = 1'b0;
    wr(1, 8'h17);
    strobe();
    chk("R10 combined febe 0", {7'b0, tx_febe}, 8'h00);
    rd_chk("R10 request cleared", 1, 8'h1F);
    crc_ok = 1'b1;
    strobe();
    chk("R10 single febe only", {7'b0, tx_febe}, 8'h01);
  endtask

  task automatic t_unmapped();
    rd_chk("R12 unmapped read", 3, 8'h00);
    wr(3, 8'hFF);
    rd_chk("R12 m4 untouched", 0, 8'hC3);
    rd_chk("R12 m56 untouched", 1, 8'h1F);
    rd_chk("R12 ctl untouched", 2, 8'h07);
  endtask

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    sf_strobe = 1'b0; link_active = 1'b0; act_in = 1'b0; dea_in = 1'b0;
    uoa_in = 1'b0; crc_ok = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_frame();
    t_inactive();
    t_strobe_write();
    t_febx_gate_off();
    t_febx_one_shot();
    t_febx_in_strobe();
    t_crc();
    t_fal();
    t_combo();
    t_unmapped();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule